// File: doc/BRIEF.md
# Serial Bus Clock and Bit Counter

This block is the byte-transfer engine of a standard-mode two-wire serial master. It holds one 8-bit control word. The word sets three things: a clock divider that derives SCL from the system clock, the number of data bits sent per transfer, and whether an extra acknowledge clock follows the data. A one-cycle start strobe launches a transfer. The engine then drives SCL low and high for a programmed number of pulses and presents the byte on SDA most significant bit first. It raises a one-cycle completion pulse after the last SCL pulse has ended.

Each SCL period is split into a low half and a high half of equal length. With clock code `c` (0..6), each half lasts `2^(c+4) + 4` system clocks, so the full period is `2^(c+5) + 8` clocks. Code 7 is reserved, and a start strobe under that code is refused. A software-reset input forces the engine idle with SCL high. While that input is asserted, the low bit of the readback word reads 0.

Top module: `sbus_xfer_engine`

## Requirements
- R1: After reset, `scl` and `sda` are 1, `busy` and `done` are 0, and `cfg_rdata` reads 8'h01.
- R2: A write with `cfg_we` stores all of `cfg_wdata` at once. The fields are: bits 7:5 are the bit-count code, bit 4 enables the acknowledge clock, bit 3 is a spare bit, and bits 2:0 are the clock code. `cfg_rdata` returns bits 7:1 as last written. Bit 0 of `cfg_rdata` is the reset monitor: it reads 1 when `soft_rst` is low and 0 when `soft_rst` is high.
- R3: In every SCL period of a transfer, `scl` is low for `2^(c+4)+4` clocks and then high for the same number of clocks. The first low half begins at the clock edge that samples `start`.
- R4: The bit-count code `b` selects `b` data bits. A code of 0 selects 8 data bits.
- R5: When bit 4 is set, one extra SCL pulse follows the data bits, and `sda` is 1 throughout that pulse.
- R6: Data bits leave `tx_byte` starting from bit 7 and moving downward. While `busy` is 1, `sda` changes only while `scl` is low.
- R7: `done` is high for exactly one clock. It rises `2*H*P` clocks after the edge that samples `start`, where `H` is the half-period length and `P` is the pulse count. At that point `busy` falls and `scl` is 1.
- R8: A start strobe under clock code 7 has no effect: `busy` stays 0 and `scl` stays 1.
- R9: A start strobe while a transfer is running has no effect on that transfer.
- R10: While `soft_rst` is 1, the engine is idle with `scl` high and `busy` low, and bit 0 of `cfg_rdata` reads 0. The stored control bits keep their values.
- R11: The transfer uses the control word and byte captured when `start` is accepted. Control writes made during a transfer do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Software reset: holds engine idle |
| cfg_we | input | 1 | Whole-byte control write strobe |
| cfg_wdata | input | 8 | Control write data |
| cfg_rdata | output | 8 | Control readback with reset monitor in bit 0 |
| start | input | 1 | Transfer start strobe |
| tx_byte | input | 8 | Byte to send, captured at start |
| scl | output | 1 | Serial clock level |
| sda | output | 1 | Serial data level (1 = released) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The embedded assertions check the following on every cycle:
- `sda` does not change while `scl` is high during a transfer.
- `done` lasts one clock and appears only when `scl` is high and the engine is idle.
- A reserved-code start never makes the engine busy.
- `soft_rst` forces the engine idle with `scl` high.
- `sda` stays released during the acknowledge pulse.
- The divider counter never exceeds its reload value.

The following can only be shown by the bench scenarios, which compare each result with values computed in the bench:
- the exact half-period length for each clock code;
- the pulse count for each bit-count and acknowledge setting;
- the order of the bits sampled at each rising SCL edge;
- the total latency to `done`;
- immunity to writes and extra starts during a transfer.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOW  = 2'd1,
      ST_HIGH = 2'd2
   } sbus_state_e;

   // Half-period length in system clocks for code c: 2^(c+EXP_BASE-1) + HALF_ADD
   function automatic int unsigned half_len(input int unsigned code,
                                            input int unsigned exp_base,
                                            input int unsigned half_add);
      return (32'd1 << (code + exp_base - 1)) + half_add;
   endfunction
endpackage

// File: rtl/sbus_ctrl_reg.sv
module sbus_ctrl_reg #(
   parameter int REG_W = 8,
   parameter int CNT_W = 3,
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             we,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   output logic [CNT_W-1:0] bitcnt_code,
   output logic             ack_en,
   output logic [SEL_W-1:0] clk_code
);
   localparam int ACK_POS = REG_W - CNT_W - 1;

   logic [REG_W-1:0] store_q;

   generate
      if (CNT_W + SEL_W + 2 != REG_W) begin : g_bad_layout
         $error("sbus_ctrl_reg: field widths do not fill the register");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   store_q <= '0;
      else if (we)  store_q <= wdata;
   end

   assign bitcnt_code = store_q[REG_W-1 -: CNT_W];
   assign ack_en      = store_q[ACK_POS];
   assign clk_code    = store_q[SEL_W-1:0];

   // Bit 0 reads as the software-reset monitor; the rest read as stored.
   generate
      for (genvar i = 0; i < REG_W; i++) begin : g_rd
         if (i == 0) begin : g_mon
            assign rdata[i] = ~soft_rst;
         end else begin : g_pass
            assign rdata[i] = store_q[i];
         end
      end
   endgenerate

   // R10: stored bits survive a software reset
   p_keep_cfg_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_rst && !we) |=> $stable(store_q));
endmodule

// File: rtl/sbus_clk_div.sv
module sbus_clk_div
   import sbus_pkg::*;
#(
   parameter int SEL_W    = 3,
   parameter int EXP_BASE = 5,
   parameter int HALF_ADD = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic [SEL_W-1:0] idle_code,
   input  logic [SEL_W-1:0] run_code,
   output logic             tick
);
   localparam int MAX_CODE = (1 << SEL_W) - 1;
   localparam int MAX_HALF = (1 << (MAX_CODE + EXP_BASE - 1)) + HALF_ADD;
   localparam int DIV_W    = $clog2(MAX_HALF + 1);

   generate
      if (EXP_BASE < 1) begin : g_bad_base
         $error("sbus_clk_div: EXP_BASE must be at least 1");
      end
   endgenerate

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] idle_load, run_load;

   assign idle_load = DIV_W'(half_len(int'(idle_code), EXP_BASE, HALF_ADD) - 1);
   assign run_load  = DIV_W'(half_len(int'(run_code),  EXP_BASE, HALF_ADD) - 1);
   assign tick      = run && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clr)     cnt_q <= '0;
      else if (!run)    cnt_q <= idle_load;
      else if (tick)    cnt_q <= run_load;
      else              cnt_q <= cnt_q - 1'b1;
   end

   // R3: a running count never exceeds the reload for the active code
   p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n || clr)
      ($past(run) && run) |-> (cnt_q <= run_load));
endmodule

// File: rtl/sbus_bit_seq.sv
module sbus_bit_seq
   import sbus_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int CNT_W     = 3,
   parameter int SEL_W     = 3,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              start,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic [CNT_W-1:0]  bitcnt_code,
   input  logic              ack_en,
   input  logic [SEL_W-1:0]  clk_code,
   input  logic              tick,
   output logic [SEL_W-1:0]  run_code,
   output logic              scl,
   output logic              sda,
   output logic              busy,
   output logic              done
);
   localparam int PC_W = $clog2(DATA_W + 2);
   localparam logic [SEL_W-1:0] RSV_CODE = '1;

   generate
      if (DATA_W != (1 << CNT_W)) begin : g_bad_len
         $error("sbus_bit_seq: code zero must map to the full data width");
      end
   endgenerate

   sbus_state_e      state_q;
   logic [DATA_W-1:0] shr_q;
   logic [PC_W-1:0]  pulse_q, npulse_q, ndata_q;
   logic             ack_q, scl_q, sda_q, done_q;
   logic [SEL_W-1:0] code_q;
   logic             accept;
   logic [PC_W-1:0]  req_len;
   logic             head_bit, head_next;
   logic [DATA_W-1:0] shr_adv, load_adv;

   assign req_len = (bitcnt_code == '0) ? PC_W'(DATA_W) : PC_W'(bitcnt_code);
   assign accept  = (state_q == ST_IDLE) && start && !soft_rst && (clk_code != RSV_CODE);

   generate
      if (MSB_FIRST) begin : g_msb
         assign head_bit  = tx_byte[DATA_W-1];
         assign load_adv  = tx_byte << 1;
         assign head_next = shr_q[DATA_W-1];
         assign shr_adv   = shr_q << 1;
      end else begin : g_lsb
         assign head_bit  = tx_byte[0];
         assign load_adv  = tx_byte >> 1;
         assign head_next = shr_q[0];
         assign shr_adv   = shr_q >> 1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         shr_q    <= '0;
         pulse_q  <= '0;
         npulse_q <= '0;
         ndata_q  <= '0;
         ack_q    <= 1'b0;
         code_q   <= '0;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
         done_q   <= 1'b0;
      end else if (soft_rst) begin
         state_q  <= ST_IDLE;
         pulse_q  <= '0;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               code_q <= clk_code;
               if (accept) begin
                  state_q  <= ST_LOW;
                  scl_q    <= 1'b0;
                  sda_q    <= head_bit;
                  shr_q    <= load_adv;
                  pulse_q  <= '0;
                  ndata_q  <= req_len;
                  ack_q    <= ack_en;
                  npulse_q <= req_len + PC_W'(ack_en);
               end
            end
            ST_LOW: begin
               if (tick) begin
                  state_q <= ST_HIGH;
                  scl_q   <= 1'b1;
               end
            end
            ST_HIGH: begin
               if (tick) begin
                  if (pulse_q == npulse_q - 1'b1) begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                     sda_q   <= 1'b1;
                  end else begin
                     state_q <= ST_LOW;
                     scl_q   <= 1'b0;
                     pulse_q <= pulse_q + 1'b1;
                     sda_q   <= (pulse_q + 1'b1 < ndata_q) ? head_next : 1'b1;
                     shr_q   <= shr_adv;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign run_code = code_q;
   assign scl      = scl_q;
   assign sda      = sda_q;
   assign busy     = (state_q != ST_IDLE);
   assign done     = done_q;

   // R6: data only moves while the clock is low
   p_sda_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && scl && $past(scl) && $past(busy)) |-> $stable(sda));
   // R7: completion is a single-cycle pulse with the line idle
   p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (scl && !busy));
   // R8: a reserved clock code never launches a transfer
   p_rsv_refused_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && clk_code == RSV_CODE) |=> !busy);
   // R10: software reset idles the engine
   p_soft_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (scl && !busy));
   // R5: acknowledge pulse keeps the data line released
   p_ack_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ack_q && pulse_q == ndata_q) |-> sda);
endmodule

// File: rtl/sbus_xfer_engine.sv
module sbus_xfer_engine #(
   parameter int DATA_W   = 8,
   parameter int CNT_W    = 3,
   parameter int SEL_W    = 3,
   parameter int EXP_BASE = 5,
   parameter int HALF_ADD = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              cfg_we,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   input  logic              start,
   input  logic [DATA_W-1:0] tx_byte,
   output logic              scl,
   output logic              sda,
   output logic              busy,
   output logic              done
);
   localparam int REG_W = 8;

   logic [CNT_W-1:0] bitcnt_code;
   logic             ack_en;
   logic [SEL_W-1:0] clk_code, run_code;
   logic             tick;

   sbus_ctrl_reg #(.REG_W(REG_W), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_reg (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .we(cfg_we), .wdata(cfg_wdata), .rdata(cfg_rdata),
      .bitcnt_code(bitcnt_code), .ack_en(ack_en), .clk_code(clk_code)
   );

   sbus_clk_div #(.SEL_W(SEL_W), .EXP_BASE(EXP_BASE), .HALF_ADD(HALF_ADD)) u_div (
      .clk(clk), .rst_n(rst_n), .clr(soft_rst), .run(busy),
      .idle_code(clk_code), .run_code(run_code), .tick(tick)
   );

   sbus_bit_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SEL_W(SEL_W), .MSB_FIRST(1'b1)) u_seq (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .start(start),
      .tx_byte(tx_byte), .bitcnt_code(bitcnt_code), .ack_en(ack_en),
      .clk_code(clk_code), .tick(tick), .run_code(run_code),
      .scl(scl), .sda(sda), .busy(busy), .done(done)
   );
endmodule

// File: tb/sbus_xfer_engine_test.sv
module sbus_xfer_engine_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       soft_rst = 1'b0;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cfg_rdata;
   logic       start = 1'b0;
   logic [7:0] tx_byte = '0;
   logic       scl, sda, busy, done;

   int checks = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sbus_xfer_engine uut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .start(start), .tx_byte(tx_byte),
      .scl(scl), .sda(sda), .busy(busy), .done(done)
   );

   function automatic int half_exp(input int code);
      return (1 << (code + 4)) + 4;
   endfunction

   function automatic int len_exp(input int bc);
      return (bc == 0) ? 8 : bc;
   endfunction

   function automatic logic [8:0] bits_exp(input logic [7:0] d, input int len, input bit ack);
      logic [8:0] v = '0;
      for (int i = 0; i < len; i++) v[i] = d[7-i];
      if (ack) v[len] = 1'b1;
      return v;
   endfunction

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [7:0] v);
      @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   // Runs one transfer and checks timing, pulse count and bit order.
   task automatic run_xfer(input int bc, input bit ack, input int code,
                           input logic [7:0] data, input bit disturb);
      int h, len, p, k, rises, first_high, low_run, bad_low;
      logic [8:0] got, expv;
      bit prev_scl;
      h = half_exp(code); len = len_exp(bc); p = len + int'(ack);
      cfg_write({3'(bc), ack, 1'b0, 3'(code)});
      @(negedge clk); start = 1'b1; tx_byte = data;
      @(posedge clk);
      @(negedge clk); start = 1'b0; tx_byte = ~data;
      k = 0; rises = 0; first_high = -1; got = '0; prev_scl = scl;
      low_run = (scl == 1'b0) ? 1 : 0; bad_low = 0;
      while (!done && k < 40000) begin
         if (disturb && k == 3) begin cfg_we = 1'b1; cfg_wdata = 8'hFF; start = 1'b1; end
         if (disturb && k == 4) begin cfg_we = 1'b0; start = 1'b0; end
         @(posedge clk); @(negedge clk); k++;
         if (scl && !prev_scl) begin
            if (rises < 9) got[rises] = sda;
            rises++;
            if (first_high < 0) first_high = k;
            if (low_run != h) bad_low++;
         end
         if (!scl) low_run = prev_scl ? 1 : low_run + 1;
         prev_scl = scl;
      end
      expv = bits_exp(data, len, ack);
      check("R3 first low half", first_high, h);
      check("R3 low half lengths", bad_low, 0);
      check(ack ? "R5 pulse count with ack" : "R4 pulse count", rises, p);
      check("R6 bit order", got, expv);
      check("R7 done latency", k, 2*h*p);
      @(negedge clk);
      check("R7 done single cycle", {done, busy, scl}, 3'b001);
      if (disturb) check("R11 R9 register took late write", cfg_rdata, 8'hFF);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 reset outputs", {scl, sda, busy, done}, 4'b1100);
      check("R1 reset readback", cfg_rdata, 8'h01);

      // R2 whole-byte write and readback
      cfg_write(8'hA6);
      check("R2 readback", cfg_rdata, 8'hA7);
      cfg_write(8'h5B);
      check("R2 readback", cfg_rdata, 8'h5B);

      // Directed corners: R4 code zero, R5 ack, R6 order
      run_xfer(0, 1'b0, 0, 8'hB4, 1'b0);
      run_xfer(0, 1'b1, 0, 8'h3C, 1'b0);
      run_xfer(1, 1'b1, 1, 8'h80, 1'b0);
      run_xfer(7, 1'b0, 2, 8'hD5, 1'b0);
      run_xfer(1, 1'b0, 6, 8'h7F, 1'b0);   // slowest clock code
      // R9 R11: late write and second start during a transfer
      run_xfer(3, 1'b1, 0, 8'hC9, 1'b1);

      // Random mix
      for (int i = 0; i < 10; i++) begin
         run_xfer(int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                  int'($urandom_range(0, 3)), 8'($urandom_range(0, 255)), 1'b0);
      end

      // R8 reserved clock code refuses start
      begin
         int seen;
         seen = 0;
         cfg_write(8'h07);
         @(negedge clk); start = 1'b1; tx_byte = 8'h00;
         @(negedge clk); start = 1'b0;
         for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (busy || !scl || done) seen++;
         end
         check("R8 reserved code ignored", seen, 0);
      end

      // R10 software reset during a transfer
      cfg_write(8'h42);
      @(negedge clk); start = 1'b1; tx_byte = 8'h00;
      @(negedge clk); start = 1'b0;
      repeat (30) @(negedge clk);
      check("R10 engine running before soft reset", busy, 1);
      soft_rst = 1'b1;
      @(negedge clk);
      check("R10 idle under soft reset", {scl, busy}, 2'b10);
      check("R10 monitor low", cfg_rdata, 8'h42);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      check("R10 start ignored in soft reset", busy, 0);
      soft_rst = 1'b0;
      @(negedge clk);
      check("R10 monitor released", cfg_rdata, 8'h43);
      run_xfer(2, 1'b0, 1, 8'h9A, 1'b0);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule